// File: doc/BRIEF.md
# General-Purpose Output Selector with Reference Clock Divider

This block drives a single general-purpose output pin. A 3-bit selector picks what the pin carries: a divided copy of the reference clock, serial read data, a combined mode in which the pin shows the clock while chip select is idle (high) and serial read data while chip select is active (low), one of two status flags, or a copy of a register data bit. Two selector codes are reserved and drive the pin low.

The reference clock divider is part of the block. A 3-bit divider code picks a ratio of 1, 2, 4, 8 or 16. A new code is applied only at the start of a low phase of the divided clock, so a ratio change never shortens a pulse. The clock reaches the pin only when the clock-output enable is set; while the device is in shutdown it also needs the clock-in-shutdown enable. When gated off, the clock path sits low.

Top module: `gpo_pin_mux`

## Requirements
- R1: Divider code 000 passes the reference clock through; 001 divides by 2, 010 by 4, 011 by 8, and any code 1xx by 16. For every ratio of 2 or more the divided clock is high for exactly half of each period.
- R2: A new divider code is applied at the clock edge where the divided clock falls: the high phase in progress keeps its full length, and the new ratio starts with a full low phase.
- R3: Selector 000 drives the gated clock while cs_n_i is 1 and drives sdo_i while cs_n_i is 0.
- R4: Selector 001 always drives sdo_i; selector 010 always drives the gated clock.
- R5: Selector 101 drives no_osc_i, selector 110 drives pll_ready_i, selector 111 drives data_bit_i.
- R6: Selectors 011 and 100 drive the pin low whatever the other inputs are.
- R7: The clock reaches the pin only when clkout_en_i is 1, and while shutdown_i is 1 only when clk_in_sd_i is also 1; otherwise the clock path holds low.
- R8: While rst_ni is 0 the divided clock is held low, so the clock selections drive the pin low even with the clock enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, also the source of the divided clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Pin source selector |
| div_code_i | input | 3 | Divider ratio code |
| clkout_en_i | input | 1 | Clock-output enable |
| clk_in_sd_i | input | 1 | Keep the clock output running during shutdown |
| shutdown_i | input | 1 | Device is in shutdown |
| cs_n_i | input | 1 | Serial interface chip select, active low |
| sdo_i | input | 1 | Serial read data |
| no_osc_i | input | 1 | Oscillator-absent status flag |
| pll_ready_i | input | 1 | Synthesizer-locked status flag |
| data_bit_i | input | 1 | Register data bit to mirror |
| pin_o | output | 1 | Output pin value |

## Verification
The selector path has no register, so every static selection is due in the same cycle the inputs change; the bench drives on the falling edge and samples two time units after the following rising and falling edges, where a pass-through clock must read 1 and 0 respectively. The divided clock is a flop updated at the rising edge, so divider checks sample one time unit after each rising edge, and a new code is given 40 cycles to be applied before counting, which covers the longest wait for a falling edge at ratio 16. The ratio-change check records the high phase in progress when the code changes and the first samples of the new ratio, which must show one cycle low then one cycle high for divide-by-2.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int SEL_W     = 3;
  localparam int DIV_W     = 3;
  localparam int MAX_SHIFT = 4;                       // largest ratio is 2**MAX_SHIFT
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = (MAX_SHIFT > 1) ? MAX_SHIFT - 1 : 1;

  typedef enum logic [SEL_W-1:0] {
    PIN_CLK_OR_SDO = 3'b000,
    PIN_SDO        = 3'b001,
    PIN_CLK        = 3'b010,
    PIN_RSV_A      = 3'b011,
    PIN_RSV_B      = 3'b100,
    PIN_NO_OSC     = 3'b101,
    PIN_READY      = 3'b110,
    PIN_DATA       = 3'b111
  } pin_sel_e;

  // Ratio exponent for a divider code: top bit set means the largest ratio.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [DIV_W-1:0] code);
    if (code[DIV_W-1]) return SHIFT_W'(MAX_SHIFT);
    return SHIFT_W'(code[DIV_W-2:0]);
  endfunction

  // Cycles per half period, minus one, for a ratio exponent of 1 or more.
  function automatic logic [CNT_W-1:0] half_minus1(input logic [SHIFT_W-1:0] sh);
    logic [CNT_W:0] h;
    h = 1;
    h = h << (sh - 1'b1);
    return CNT_W'(h - 1'b1);
  endfunction
endpackage

// File: rtl/gpo_refdiv.sv
module gpo_refdiv
  import gpo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] code_i,
  output logic             clk_div_o,
  output logic             load_o,
  output logic             level_o,
  output logic [DIV_W-1:0] act_code_o
);
  logic [DIV_W-1:0]   act_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               lvl_q;
  logic               byp_q;
  logic [SHIFT_W-1:0] act_shift;
  logic               half_done;

  assign act_shift = code_to_shift(act_q);
  assign half_done = (act_shift != '0) && (cnt_q == half_minus1(act_shift));
  // Pass-through mode may switch on any edge; divided modes only as the level falls.
  assign load_o    = (act_shift == '0) || (half_done && lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_o) begin
      act_q <= code_i;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (half_done) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Bypass select moves while the reference clock is low and the divided level is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= (act_shift == '0);
  end

  assign clk_div_o  = byp_q ? clk_i : lvl_q;
  assign level_o    = lvl_q;
  assign act_code_o = act_q;
endmodule

// File: rtl/gpo_clkgate.sv
module gpo_clkgate (
  input  logic clk_div_i,
  input  logic out_en_i,
  input  logic in_sd_en_i,
  input  logic shutdown_i,
  output logic clk_on_o,
  output logic clk_o
);
  assign clk_on_o = out_en_i && (!shutdown_i || in_sd_en_i);
  assign clk_o    = clk_on_o & clk_div_i;
endmodule

// File: rtl/gpo_pinsel.sv
module gpo_pinsel
  import gpo_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clk_g_i,
  input  logic             cs_n_i,
  input  logic             sdo_i,
  input  logic             no_osc_i,
  input  logic             ready_i,
  input  logic             data_i,
  output logic             pin_o
);
  always_comb begin
    unique case (pin_sel_e'(sel_i))
      PIN_CLK_OR_SDO: pin_o = cs_n_i ? clk_g_i : sdo_i;
      PIN_SDO:        pin_o = sdo_i;
      PIN_CLK:        pin_o = clk_g_i;
      PIN_NO_OSC:     pin_o = no_osc_i;
      PIN_READY:      pin_o = ready_i;
      PIN_DATA:       pin_o = data_i;
      default:        pin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpo_pin_mux.sv
module gpo_pin_mux
  import gpo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             clkout_en_i,
  input  logic             clk_in_sd_i,
  input  logic             shutdown_i,
  input  logic             cs_n_i,
  input  logic             sdo_i,
  input  logic             no_osc_i,
  input  logic             pll_ready_i,
  input  logic             data_bit_i,
  output logic             pin_o
);
  // Named internal events, observed by the bound checker.
  logic             clk_div;
  logic             div_load;
  logic             div_lvl;
  logic [DIV_W-1:0] act_code;
  logic             clk_on;
  logic             clk_gated;

  gpo_refdiv u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (div_code_i),
    .clk_div_o  (clk_div),
    .load_o     (div_load),
    .level_o    (div_lvl),
    .act_code_o (act_code)
  );

  gpo_clkgate u_gate (
    .clk_div_i  (clk_div),
    .out_en_i   (clkout_en_i),
    .in_sd_en_i (clk_in_sd_i),
    .shutdown_i (shutdown_i),
    .clk_on_o   (clk_on),
    .clk_o      (clk_gated)
  );

  gpo_pinsel u_sel (
    .sel_i    (sel_i),
    .clk_g_i  (clk_gated),
    .cs_n_i   (cs_n_i),
    .sdo_i    (sdo_i),
    .no_osc_i (no_osc_i),
    .ready_i  (pll_ready_i),
    .data_i   (data_bit_i),
    .pin_o    (pin_o)
  );
endmodule

// File: rtl/gpo_pin_mux_chk.sv
module gpo_pin_mux_chk
  import gpo_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             cs_n_i,
  input logic             sdo_i,
  input logic             no_osc_i,
  input logic             pll_ready_i,
  input logic             data_bit_i,
  input logic             pin_o,
  input logic             div_load,
  input logic             div_lvl,
  input logic [DIV_W-1:0] act_code,
  input logic             clk_on
);
  assert_lvl_rise_divided_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_lvl) |-> (act_code != '0));

  assert_load_starts_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load |=> !div_lvl);

  assert_code_moves_on_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_code) |-> $past(div_load));

  assert_combined_sdo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000 && !cs_n_i) |-> (pin_o == sdo_i));

  assert_sdo_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |-> (pin_o == sdo_i));

  assert_flag_osc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b101) |-> (pin_o == no_osc_i));

  assert_flag_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b110) |-> (pin_o == pll_ready_i));

  assert_data_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b111) |-> (pin_o == data_bit_i));

  assert_reserved_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b011 || sel_i == 3'b100) |-> !pin_o);

  assert_gated_clock_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b010 && !clk_on) |-> !pin_o);
endmodule

bind gpo_pin_mux gpo_pin_mux_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .cs_n_i      (cs_n_i),
  .sdo_i       (sdo_i),
  .no_osc_i    (no_osc_i),
  .pll_ready_i (pll_ready_i),
  .data_bit_i  (data_bit_i),
  .pin_o       (pin_o),
  .div_load    (div_load),
  .div_lvl     (div_lvl),
  .act_code    (act_code),
  .clk_on      (clk_on)
);

// File: tb/gpo_pin_mux_test.sv
`timescale 1ns/1ps
module gpo_pin_mux_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] sel_i = 3'b010;
  logic [2:0] div_code_i = 3'b000;
  logic       clkout_en_i = 1'b1;
  logic       clk_in_sd_i = 1'b0;
  logic       shutdown_i = 1'b0;
  logic       cs_n_i = 1'b1;
  logic       sdo_i = 1'b0;
  logic       no_osc_i = 1'b0;
  logic       pll_ready_i = 1'b0;
  logic       data_bit_i = 1'b0;
  logic       pin_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  gpo_pin_mux uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .div_code_i(div_code_i),
    .clkout_en_i(clkout_en_i), .clk_in_sd_i(clk_in_sd_i), .shutdown_i(shutdown_i),
    .cs_n_i(cs_n_i), .sdo_i(sdo_i), .no_osc_i(no_osc_i), .pll_ready_i(pll_ready_i),
    .data_bit_i(data_bit_i), .pin_o(pin_o)
  );

  // sel, cs_n, sdo, no_osc, ready, data, en, shutdown, sd_en, follows clock, static value, req
  typedef struct packed {
    logic [2:0] sel;
    logic cs_n, sdo, osc, rdy, dat, en, sd, sden, follow, val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 3},  // R3 idle CS shows clock
    '{3'b000, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 3},  // R3 active CS shows sdo=1
    '{3'b000, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 3},  // R3 active CS shows sdo=0
    '{3'b001, 1, 1, 0, 0, 0, 1, 0, 0, 0, 1, 4},  // R4 sdo only
    '{3'b001, 1, 0, 1, 1, 1, 1, 0, 0, 0, 0, 4},  // R4
    '{3'b010, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0, 4},  // R4 clock only
    '{3'b010, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 7},  // R7 enable off
    '{3'b010, 1, 0, 0, 0, 0, 1, 1, 0, 0, 0, 7},  // R7 shutdown without keep
    '{3'b010, 1, 0, 0, 0, 0, 1, 1, 1, 1, 0, 7},  // R7 shutdown with keep
    '{3'b000, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 7},  // R7 combined mode, enable off
    '{3'b101, 1, 0, 1, 0, 0, 1, 0, 0, 0, 1, 5},  // R5 oscillator flag
    '{3'b101, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 5},  // R5
    '{3'b110, 1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 5},  // R5 ready flag
    '{3'b111, 1, 0, 0, 0, 1, 1, 0, 0, 0, 1, 5},  // R5 data copy
    '{3'b111, 1, 1, 1, 1, 0, 1, 0, 0, 0, 0, 5},  // R5
    '{3'b011, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 6},  // R6 reserved
    '{3'b100, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 6}   // R6 reserved
  };

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // R1: count highs and rising edges of the divided clock over 64 rising-edge samples.
  task automatic measure(input logic [2:0] code, input int ratio);
    int highs = 0;
    int rises = 0;
    logic prev;
    @(negedge clk_i);
    div_code_i = code;
    sel_i = 3'b010; clkout_en_i = 1'b1; shutdown_i = 1'b0;
    repeat (40) @(posedge clk_i);
    #1 prev = pin_o;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk_i); #1;
      if (pin_o) highs++;
      if (pin_o && !prev) rises++;
      prev = pin_o;
    end
    check_int(highs, 32, "R1", $sformatf("high samples at code %b", code));
    check_int(rises, 64 / ratio, "R1", $sformatf("periods at code %b", code));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int run;
    rst_ni = 1'b0;
    // R8: in reset the clock selection stays low even while enabled and at clk high.
    repeat (3) @(posedge clk_i);
    #2 check(pin_o, 1'b0, "R8", "clock selection during reset, clk high");
    @(negedge clk_i); #2 check(pin_o, 1'b0, "R8", "clock selection during reset, clk low");
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);

    // R1: pass-through follows the reference clock.
    #2 check(pin_o, 1'b1, "R1", "pass-through high phase");
    @(negedge clk_i); #2 check(pin_o, 1'b0, "R1", "pass-through low phase");

    measure(3'b001, 2);
    measure(3'b010, 4);
    measure(3'b011, 8);
    measure(3'b111, 16);
    measure(3'b100, 16);

    // R2: change ratio in the middle of a divide-by-16 high phase.
    do begin
      @(posedge clk_i); #1;
    end while (pin_o);
    do begin
      @(posedge clk_i); #1;
    end while (!pin_o);
    run = 1;
    @(negedge clk_i);
    div_code_i = 3'b001;
    forever begin
      @(posedge clk_i); #1;
      if (!pin_o) break;
      run++;
    end
    check_int(run, 8, "R2", "high phase in progress at code change");
    @(posedge clk_i); #1 check(pin_o, 1'b1, "R2", "new ratio first high");
    @(posedge clk_i); #1 check(pin_o, 1'b0, "R2", "new ratio second low");
    @(posedge clk_i); #1 check(pin_o, 1'b1, "R2", "new ratio second high");

    // R1: back to pass-through.
    @(negedge clk_i);
    div_code_i = 3'b000;
    repeat (6) @(posedge clk_i);
    #2 check(pin_o, 1'b1, "R1", "return to pass-through high");
    @(negedge clk_i); #2 check(pin_o, 1'b0, "R1", "return to pass-through low");

    // Selector table, pass-through clock.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      sel_i = VECS[i].sel; cs_n_i = VECS[i].cs_n; sdo_i = VECS[i].sdo;
      no_osc_i = VECS[i].osc; pll_ready_i = VECS[i].rdy; data_bit_i = VECS[i].dat;
      clkout_en_i = VECS[i].en; shutdown_i = VECS[i].sd; clk_in_sd_i = VECS[i].sden;
      @(posedge clk_i);
      #2 check(pin_o, VECS[i].follow ? 1'b1 : VECS[i].val,
               $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d clk high", i));
      @(negedge clk_i);
      #2 check(pin_o, VECS[i].follow ? 1'b0 : VECS[i].val,
               $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d clk low", i));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule